// File: doc/BRIEF.md
# Split Instruction/Data Request Steering Unit

This unit sits in front of two small tag arrays, one for instruction lines and one for data lines. It receives processor requests (load, store, atomic, instruction fetch) and messages from the next cache level. For each processor request it decides which array to search. It then tells the per-line controller what to do by raising one event per cycle: a hit, a miss that allocates a way, a replacement that frees a way, or an invalidation. It holds the tags, valid bits, in-flight marks and the per-set recency bit. It does not hold data, and it does not track coherence state.

A line may sit in only one of the two arrays. If a request misses its own array but finds the line in the other one, the unit first evicts the line from the other array. If the target set is full, it first evicts a victim. In both cases the request is kept and evaluated again on the next cycle, until it ends in a hit or a miss. A request to a line whose fill is still outstanding is parked. It wakes when a message from the next level touches that set. Messages from the next level always take precedence over processor requests.

Top module: `idsteer`

## Requirements
- R1: Op code 2'b11 (instruction fetch) searches the instruction array and its events carry `evt_iside`=1. Op codes 2'b00 (load), 2'b01 (store) and 2'b10 (atomic) search the data array and carry `evt_iside`=0.
- R2: An atomic request is handled exactly like a store: its hit or miss event has `evt_store`=1. Loads and fetches give `evt_store`=0.
- R3: Events are registered and appear in the cycle after the edge that processes the request or message. The kind codes are hit=0, miss=1, replace=2 and invalidate=3. Replace and invalidate events always have `evt_store`=0.
- R4: A request that misses its own array but hits the other array first raises a replace event for that line in the other array. Only then does the request proceed in its own array.
- R5: A request that misses a set with no free way first raises a replace event naming the victim's array, way and full line address. The miss event follows on the next cycle. `req_ready` stays low while the request is held.
- R6: A hit makes the accessed way most recently used. The victim is the least recently used way, provided it has no fill outstanding. A new allocation takes way 0 first when both ways are free.
- R7: A request to a line whose miss has been raised but whose completion (net op 0) has not arrived is parked. It raises no event and holds `req_ready` low until a completion or invalidation arrives for the same set. It is then evaluated again.
- R8: While `net_valid` is high, `req_ready` is low and no processor request is evaluated. The message is handled in that cycle.
- R9: Net op 1 removes the named line from whichever array holds it and raises an invalidate event with its array and way. If the line is absent, nothing is raised. Net op 0 clears the outstanding-fill mark and raises no event.
- R10: No line address is ever valid in both arrays at the same time.
- R11: After reset both arrays are empty, `evt_valid` is 0, and `req_ready` is 1 when no message is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_op | input | 2 | 00 load, 01 store, 10 atomic, 11 fetch |
| req_line | input | LINE_W | Line address, set index in low bits |
| net_valid | input | 1 | Next-level message present |
| net_op | input | 1 | 0 fill complete, 1 invalidate |
| net_line | input | LINE_W | Line address of the message |
| evt_valid | output | 1 | Event present |
| evt_kind | output | 2 | 0 hit, 1 miss, 2 replace, 3 invalidate |
| evt_iside | output | 1 | 1 instruction array, 0 data array |
| evt_way | output | 1 | Way concerned |
| evt_store | output | 1 | Request needs write permission |
| evt_line | output | LINE_W | Line address concerned |

## Verification
A wrong tag, valid or in-flight bit becomes visible one cycle later as the wrong event kind, a hit or miss on the wrong way, or a missing replace ahead of a miss. A corrupted recency bit only shows at the next eviction in that set, when the wrong victim line is named. A stuck hold or park flag shows at once as `req_ready` low with no event. If the two arrays lose exclusivity, a second lookup of the line produces a hit where a replace was due.

// File: rtl/idsteer.sv
module idsteer #(
  parameter int LINE_W   = 10,
  parameter int SET_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [LINE_W-1:0] req_line,
  input  logic              net_valid,
  input  logic              net_op,
  input  logic [LINE_W-1:0] net_line,
  output logic              evt_valid,
  output logic [1:0]        evt_kind,
  output logic              evt_iside,
  output logic              evt_way,
  output logic              evt_store,
  output logic [LINE_W-1:0] evt_line
);
  localparam int SETS  = 1 << SET_BITS;
  localparam int TAG_W = LINE_W - SET_BITS;
  localparam logic [1:0] EV_HIT = 2'd0, EV_MISS = 2'd1, EV_REPL = 2'd2, EV_INV = 2'd3;

  typedef enum logic [2:0] {A_PARK, A_HIT, A_XREPL, A_MISS, A_VREPL} act_t;

  logic [TAG_W-1:0] tag_q [2][SETS][2];
  logic             vld_q [2][SETS][2];
  logic             bsy_q [2][SETS][2];
  logic             lru_q [2][SETS];

  logic              pend_q, park_q, hold_inst_q, hold_st_q;
  logic [LINE_W-1:0] hold_line_q;

  logic              cur_inst, cur_st, cur_go, t, o;
  logic [LINE_W-1:0] cur_line;
  logic [SET_BITS-1:0] c_set, n_set;
  logic [TAG_W-1:0]  c_tag, n_tag;

  assign cur_inst  = pend_q ? hold_inst_q : (req_op == 2'b11);
  assign cur_st    = pend_q ? hold_st_q   : (req_op[1] ^ req_op[0]);
  assign cur_line  = pend_q ? hold_line_q : req_line;
  assign req_ready = !net_valid && !pend_q;
  assign cur_go    = !net_valid && (pend_q ? !park_q : req_valid);
  assign c_set     = cur_line[SET_BITS-1:0];
  assign c_tag     = cur_line[LINE_W-1:SET_BITS];
  assign n_set     = net_line[SET_BITS-1:0];
  assign n_tag     = net_line[LINE_W-1:SET_BITS];
  assign t         = cur_inst;
  assign o         = !cur_inst;

  logic [1:0] thit, ohit;
  logic       tway, oway, fway, has_free, lru, vok, vway;
  act_t       act;

  always_comb begin
    for (int w = 0; w < 2; w++) begin
      thit[w] = vld_q[t][c_set][w] && (tag_q[t][c_set][w] == c_tag);
      ohit[w] = vld_q[o][c_set][w] && (tag_q[o][c_set][w] == c_tag);
    end
    tway     = thit[1];
    oway     = ohit[1];
    fway     = vld_q[t][c_set][0];
    has_free = !(vld_q[t][c_set][0] && vld_q[t][c_set][1]);
    lru      = lru_q[t][c_set];
    vok      = !bsy_q[t][c_set][lru] || !bsy_q[t][c_set][!lru];
    vway     = bsy_q[t][c_set][lru] ? !lru : lru;
    if (|thit)      act = bsy_q[t][c_set][tway] ? A_PARK : A_HIT;
    else if (|ohit) act = bsy_q[o][c_set][oway] ? A_PARK : A_XREPL;
    else if (has_free) act = A_MISS;
    else if (vok)   act = A_VREPL;
    else            act = A_PARK;
  end

  logic nhit, n_arr, n_way;
  always_comb begin
    nhit = 1'b0; n_arr = 1'b0; n_way = 1'b0;
    for (int a = 0; a < 2; a++)
      for (int w = 0; w < 2; w++)
        if (vld_q[a][n_set][w] && tag_q[a][n_set][w] == n_tag) begin
          nhit = 1'b1; n_arr = a[0]; n_way = w[0];
        end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < 2; a++)
        for (int s = 0; s < SETS; s++) begin
          lru_q[a][s] <= 1'b0;
          for (int w = 0; w < 2; w++) begin
            tag_q[a][s][w] <= '0;
            vld_q[a][s][w] <= 1'b0;
            bsy_q[a][s][w] <= 1'b0;
          end
        end
      pend_q <= 1'b0; park_q <= 1'b0; hold_inst_q <= 1'b0; hold_st_q <= 1'b0;
      hold_line_q <= '0;
      evt_valid <= 1'b0; evt_kind <= EV_HIT; evt_iside <= 1'b0; evt_way <= 1'b0;
      evt_store <= 1'b0; evt_line <= '0;
    end else begin
      evt_valid <= 1'b0;
      if (net_valid) begin
        if (nhit) begin
          bsy_q[n_arr][n_set][n_way] <= 1'b0;
          if (net_op) begin
            vld_q[n_arr][n_set][n_way] <= 1'b0;
            evt_valid <= 1'b1; evt_kind <= EV_INV; evt_iside <= n_arr;
            evt_way <= n_way; evt_store <= 1'b0; evt_line <= net_line;
          end
        end
        if (pend_q && park_q && hold_line_q[SET_BITS-1:0] == n_set) park_q <= 1'b0;
      end else if (cur_go) begin
        hold_line_q <= cur_line; hold_inst_q <= cur_inst; hold_st_q <= cur_st;
        case (act)
          A_HIT: begin
            lru_q[t][c_set] <= !tway;
            pend_q <= 1'b0; park_q <= 1'b0;
            evt_valid <= 1'b1; evt_kind <= EV_HIT; evt_iside <= t;
            evt_way <= tway; evt_store <= cur_st; evt_line <= cur_line;
          end
          A_XREPL: begin
            vld_q[o][c_set][oway] <= 1'b0;
            pend_q <= 1'b1; park_q <= 1'b0;
            evt_valid <= 1'b1; evt_kind <= EV_REPL; evt_iside <= o;
            evt_way <= oway; evt_store <= 1'b0; evt_line <= cur_line;
          end
          A_MISS: begin
            vld_q[t][c_set][fway] <= 1'b1;
            bsy_q[t][c_set][fway] <= 1'b1;
            tag_q[t][c_set][fway] <= c_tag;
            lru_q[t][c_set] <= !fway;
            pend_q <= 1'b0; park_q <= 1'b0;
            evt_valid <= 1'b1; evt_kind <= EV_MISS; evt_iside <= t;
            evt_way <= fway; evt_store <= cur_st; evt_line <= cur_line;
          end
          A_VREPL: begin
            vld_q[t][c_set][vway] <= 1'b0;
            pend_q <= 1'b1; park_q <= 1'b0;
            evt_valid <= 1'b1; evt_kind <= EV_REPL; evt_iside <= t;
            evt_way <= vway; evt_store <= 1'b0;
            evt_line <= {tag_q[t][c_set][vway], c_set};
          end
          default: begin
            pend_q <= 1'b1; park_q <= 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/idsteer_chk.sv
module idsteer_chk #(
  parameter int LINE_W   = 10,
  parameter int SET_BITS = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         net_valid,
  input logic                         req_ready,
  input logic                         evt_valid,
  input logic [1:0]                   evt_kind,
  input logic                         evt_store,
  input logic [LINE_W-SET_BITS-1:0]   tag_q [2][1<<SET_BITS][2],
  input logic                         vld_q [2][1<<SET_BITS][2]
);
  localparam int SETS = 1 << SET_BITS;

  // R8
  net_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    net_valid |-> !req_ready);

  // R8
  net_served_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    net_valid |=> (!evt_valid || evt_kind == 2'd3));

  // R5
  repl_holds_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind == 2'd2) |-> !req_ready);

  // R3
  evict_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_kind[1]) |-> !evt_store);

  always @(posedge clk) begin
    if (rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int a = 0; a < 2; a++)
          for (int b = 0; b < 2; b++)
            // R10
            one_array_chk: assert (!(vld_q[0][s][a] && vld_q[1][s][b] &&
                                     tag_q[0][s][a] == tag_q[1][s][b]));
    end
  end
endmodule

bind idsteer idsteer_chk #(.LINE_W(LINE_W), .SET_BITS(SET_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .net_valid(net_valid), .req_ready(req_ready),
  .evt_valid(evt_valid), .evt_kind(evt_kind), .evt_store(evt_store),
  .tag_q(tag_q), .vld_q(vld_q)
);

// File: tb/tb_idsteer.sv
module tb_idsteer;
  localparam int LW = 10;
  localparam int SB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [1:0]    req_op = 2'b00;
  logic [LW-1:0] req_line = '0;
  logic          net_valid = 1'b0, net_op = 1'b0;
  logic [LW-1:0] net_line = '0;
  logic          evt_valid, evt_iside, evt_way, evt_store;
  logic [1:0]    evt_kind;
  logic [LW-1:0] evt_line;

  idsteer #(.LINE_W(LW), .SET_BITS(SB)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_line(req_line), .net_valid(net_valid), .net_op(net_op),
    .net_line(net_line), .evt_valid(evt_valid), .evt_kind(evt_kind),
    .evt_iside(evt_iside), .evt_way(evt_way), .evt_store(evt_store), .evt_line(evt_line)
  );

  localparam logic [1:0] LD = 2'b00, ST = 2'b01, AT = 2'b10, IF = 2'b11;
  localparam logic [1:0] K_HIT = 0, K_MISS = 1, K_REPL = 2, K_INV = 3;

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string r, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, a, e);
    end
  endtask

  task automatic expect_evt(input string r, input logic [1:0] k, input logic i,
                            input logic w, input logic s, input logic [LW-1:0] l);
    logic [15:0] act, exp;
    act = {evt_valid, evt_kind, evt_iside, evt_way, evt_store, evt_line};
    exp = {1'b1, k, i, w, s, l};
    chk(act == exp, r, {16'h0, act}, {16'h0, exp});
  endtask

  task automatic expect_none(input string r);
    chk(evt_valid == 1'b0, r, {31'h0, evt_valid}, 32'h0);
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic issue(input logic [1:0] op, input logic [LW-1:0] l);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_line = l;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
  endtask

  task automatic net(input logic op, input logic [LW-1:0] l);
    @(negedge clk);
    net_valid = 1'b1; net_op = op; net_line = l;
    #1;
    chk(req_ready == 1'b0, "R8 ready low with message", {31'h0, req_ready}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    net_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    step();
    chk(evt_valid == 1'b0, "R11 no event in reset", {31'h0, evt_valid}, 32'h0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk(req_ready == 1'b1, "R11 ready after reset", {31'h0, req_ready}, 32'h1);
    expect_none("R11 idle after reset");
  endtask

  task automatic t_fill_and_hit();
    issue(LD, 10'h004);
    expect_evt("R1 R3 load miss data way0", K_MISS, 0, 0, 0, 10'h004);
    net(1'b0, 10'h004);
    expect_none("R9 completion silent");
    issue(LD, 10'h004);
    expect_evt("R1 load hit data way0", K_HIT, 0, 0, 0, 10'h004);
    issue(IF, 10'h008);
    expect_evt("R1 fetch miss instr way0", K_MISS, 1, 0, 0, 10'h008);
    net(1'b0, 10'h008);
    issue(IF, 10'h008);
    expect_evt("R1 fetch hit instr", K_HIT, 1, 0, 0, 10'h008);
  endtask

  task automatic t_atomic();
    issue(AT, 10'h00C);
    expect_evt("R2 R6 atomic miss as store way1", K_MISS, 0, 1, 1, 10'h00C);
    net(1'b0, 10'h00C);
    issue(AT, 10'h00C);
    expect_evt("R2 atomic hit as store", K_HIT, 0, 1, 1, 10'h00C);
  endtask

  task automatic t_victim();
    issue(LD, 10'h004);
    expect_evt("R6 hit makes way0 recent", K_HIT, 0, 0, 0, 10'h004);
    issue(ST, 10'h010);
    expect_evt("R5 R6 victim is lru way1", K_REPL, 0, 1, 0, 10'h00C);
    chk(req_ready == 1'b0, "R5 held while replacing", {31'h0, req_ready}, 32'h0);
    step();
    expect_evt("R5 miss after victim", K_MISS, 0, 1, 1, 10'h010);
    net(1'b0, 10'h010);
  endtask

  task automatic t_cross();
    issue(LD, 10'h008);
    expect_evt("R4 evict from instr array", K_REPL, 1, 0, 0, 10'h008);
    step();
    expect_evt("R5 then data victim way0", K_REPL, 0, 0, 0, 10'h004);
    step();
    expect_evt("R4 then data miss", K_MISS, 0, 0, 0, 10'h008);
    net(1'b0, 10'h008);
    issue(IF, 10'h008);
    expect_evt("R4 R10 evict from data array", K_REPL, 0, 0, 0, 10'h008);
    step();
    expect_evt("R4 then instr miss", K_MISS, 1, 0, 0, 10'h008);
    net(1'b0, 10'h008);
    issue(LD, 10'h004);
    expect_evt("R5 evicted victim misses", K_MISS, 0, 0, 0, 10'h004);
    net(1'b0, 10'h004);
  endtask

  task automatic t_park();
    issue(LD, 10'h021);
    expect_evt("R7 miss set1", K_MISS, 0, 0, 0, 10'h021);
    issue(LD, 10'h021);
    expect_none("R7 parked no event");
    chk(req_ready == 1'b0, "R7 parked holds ready", {31'h0, req_ready}, 32'h0);
    step(); step();
    expect_none("R7 still parked");
    chk(req_ready == 1'b0, "R7 still not ready", {31'h0, req_ready}, 32'h0);
    net(1'b0, 10'h021);
    expect_none("R7 completion silent");
    step();
    expect_evt("R7 woken request hits", K_HIT, 0, 0, 0, 10'h021);
    chk(req_ready == 1'b1, "R7 ready after wake", {31'h0, req_ready}, 32'h1);
  endtask

  task automatic t_priority();
    @(negedge clk);
    req_valid = 1'b1; req_op = LD; req_line = 10'h021;
    net_valid = 1'b1; net_op = 1'b1; net_line = 10'h008;
    #1;
    chk(req_ready == 1'b0, "R8 request blocked", {31'h0, req_ready}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    net_valid = 1'b0;
    #1;
    expect_evt("R8 R9 message first, invalidate", K_INV, 1, 0, 0, 10'h008);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    expect_evt("R8 request after message", K_HIT, 0, 0, 0, 10'h021);
  endtask

  task automatic t_inval();
    net(1'b1, 10'h3FF);
    expect_none("R9 absent line silent");
    issue(IF, 10'h008);
    expect_evt("R9 invalidated line refetched", K_MISS, 1, 0, 0, 10'h008);
    net(1'b0, 10'h008);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_fill_and_hit();
    t_atomic();
    t_victim();
    t_cross();
    t_park();
    t_priority();
    t_inval();
    step();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule